// File: doc/BRIEF.md
# Clock power-down sequencer

This block decides when the output clocks of a multi-output clock generator may run. A free-running reference clock drives it. It turns an asynchronous, active-low power-down request into an ordered shutdown. First every gated clock output is parked low. After that the synthesizer enable drops, and after that the oscillator enable drops. When the request is released, both enables come back at once. The outputs stay low until an always-on settling tick has been counted a set number of times, which bounds the wake-up time. After this the block reports that all clocks are valid and reopens the gates.

While the block is running, an active-low stop input stops or restarts the clock groups that a parameter mask selects, within one rising edge of the reference. A select bus is captured every cycle while the block runs and is frozen otherwise. During power down, the stop and select inputs have no effect.

Each output gate opens and closes only while the reference clock is low, so every pulse that leaves the block is a full-width pulse. With the default of 25 settling ticks and a 100 µs tick, wake-up takes 2.5 ms, which is under the 3 ms budget.

Top module: `clkpwr_seq`

## Requirements
- R1: While reset is held and on the first cycle after it, `gclk_o` is all zero, `osc_en_o` and `synth_en_o` are 1, `clk_valid_o` is 0 and `sel_o` is 0.
- R2: The falling edge of `pd_req_n` passes through a two-flop synchronizer. Take the first rising edge that samples it low as edge a. `gclk_o` is still running in the high phase after edge a+2 and is all zero from the high phase after edge a+3. `synth_en_o` goes to 0 after edge a+2+PARK_CYC, and `osc_en_o` goes to 0 one edge later. The outputs are therefore parked before either enable drops.
- R3: Take the first rising edge that samples `pd_req_n` high again as edge b. `osc_en_o` and `synth_en_o` return to 1 after edge b+2. At that point `gclk_o` is still all zero and `clk_valid_o` is still 0.
- R4: After the enables return, `clk_valid_o` rises after the rising edge that samples the SETTLE_TICKS-th high `tick_i`, counting from edge b+3. All gated outputs run from the next high phase.
- R5: In the running state, `stop_n` is sampled on each rising edge e. A 0 stops, from the high phase after edge e+1, the groups whose bit in STOP_MASK is 1 (default: group 0 only). A 1 restarts them with the same latency. Groups whose mask bit is 0 keep running.
- R6: In the running state, `sel_o` equals the `sel_i` sampled at the previous rising edge. In every other state, changes on `sel_i` and `stop_n` leave `sel_o` unchanged and `gclk_o` at zero.
- R7: A gate changes only on a falling edge of `ref_clk`. In each high phase of the reference, `gclk_o` keeps a single value, and it is zero in each low phase.
- R8: After reset the block does a cold start. `clk_valid_o` rises after SETTLE_TICKS sampled ticks, counted from the first rising edge after reset.
- R9: If `pd_req_n` is asserted again during settling, the block shuts down with the R2 timing and `clk_valid_o` never rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Free-running reference clock; it is also the source of the gated outputs |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_req_n | input | 1 | Asynchronous active-low power-down request |
| stop_n | input | 1 | Active-low stop for the masked clock groups, synchronous to ref_clk |
| sel_i | input | SEL_W | Select bus, captured while running |
| tick_i | input | 1 | Always-on settling tick strobe, one cycle wide |
| osc_en_o | output | 1 | Oscillator enable |
| synth_en_o | output | 1 | Synthesizer core enable |
| gclk_o | output | NGRP | Gated clock outputs, one per group |
| sel_o | output | SEL_W | Captured select value |
| clk_valid_o | output | 1 | High while all clocks are valid and running |

## Verification
The bench checks the shutdown order cycle by cycle. A design that drops the synthesizer enable before the gates are closed would show `synth_en_o` low while a gated output is still high. The bench also counts randomly spaced settling ticks, exactly. A counter that is off by one, or one that counts untimed cycles instead of ticks, raises `clk_valid_o` on the wrong edge. The bench toggles stop, select and power down in the middle of settling and during power down, and it samples each output at two points in the high phase and once in the low phase. This catches gates that respond a cycle late, select values that leak through during power down, and truncated pulses.

// File: rtl/clkpwr_pkg.sv
package clkpwr_pkg;
    typedef enum logic [2:0] {
        PS_RUN,
        PS_PARK,
        PS_SYNOFF,
        PS_OFF,
        PS_SETTLE
    } pwr_state_e;
endpackage

// File: rtl/clkpwr_sync.sv
module clkpwr_sync #(
    parameter int STAGES  = 2,
    parameter bit RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], async_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= chain_d;
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/clkpwr_gate.sv
module clkpwr_gate #(
    parameter int NGRP = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NGRP-1:0] want_i,
    output logic [NGRP-1:0] on_o,
    output logic [NGRP-1:0] gclk_o
);
    // Enables move on the falling edge only, so each gate opens or closes
    // while its clock is low and no partial pulse can escape.
    for (genvar g = 0; g < NGRP; g++) begin : g_gate
        logic en_d, en_q;

        always_comb begin
            en_d = want_i[g];
        end

        always_ff @(negedge clk or negedge rst_n) begin
            if (!rst_n) en_q <= 1'b0;
            else        en_q <= en_d;
        end

        assign on_o[g]   = en_q;
        assign gclk_o[g] = clk & en_q;
    end
endmodule

// File: rtl/clkpwr_seq.sv
module clkpwr_seq
    import clkpwr_pkg::*;
#(
    parameter int              NGRP         = 2,
    parameter int              SEL_W        = 3,
    parameter logic [NGRP-1:0] STOP_MASK    = 2'b01,
    parameter int              PARK_CYC     = 2,
    parameter int              SETTLE_TICKS = 25
) (
    input  logic             ref_clk,
    input  logic             rst_n,
    input  logic             pd_req_n,
    input  logic             stop_n,
    input  logic [SEL_W-1:0] sel_i,
    input  logic             tick_i,
    output logic             osc_en_o,
    output logic             synth_en_o,
    output logic [NGRP-1:0]  gclk_o,
    output logic [SEL_W-1:0] sel_o,
    output logic             clk_valid_o
);
    localparam int PK_W = (PARK_CYC < 2) ? 1 : $clog2(PARK_CYC + 1);
    localparam int ST_W = (SETTLE_TICKS < 2) ? 1 : $clog2(SETTLE_TICKS + 1);

    typedef struct packed {
        pwr_state_e       st;
        logic [PK_W-1:0]  park_cnt;
        logic [ST_W-1:0]  settle_cnt;
        logic             osc_en;
        logic             synth_en;
        logic             valid;
        logic             stop;
        logic [SEL_W-1:0] sel;
    } seq_t;

    localparam seq_t SEQ_RST = '{
        st:         PS_SETTLE,
        park_cnt:   '0,
        settle_cnt: '0,
        osc_en:     1'b1,
        synth_en:   1'b1,
        valid:      1'b0,
        stop:       1'b1,
        sel:        '0
    };

    logic            pd_s;
    logic [NGRP-1:0] want;
    logic [NGRP-1:0] gate_on;
    seq_t            r_d, r_q;

    clkpwr_sync #(.STAGES(2), .RST_VAL(1'b1)) u_pd_sync (
        .clk     (ref_clk),
        .rst_n   (rst_n),
        .async_i (pd_req_n),
        .sync_o  (pd_s)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            PS_RUN: begin
                r_d.stop = stop_n;
                r_d.sel  = sel_i;
                if (!pd_s) begin
                    r_d.st       = PS_PARK;
                    r_d.park_cnt = '0;
                end
            end
            PS_PARK: begin
                if (r_q.park_cnt == PK_W'(PARK_CYC - 1)) r_d.st = PS_SYNOFF;
                else r_d.park_cnt = r_q.park_cnt + PK_W'(1);
            end
            PS_SYNOFF: r_d.st = PS_OFF;
            PS_OFF: begin
                if (pd_s) begin
                    r_d.st         = PS_SETTLE;
                    r_d.settle_cnt = '0;
                end
            end
            PS_SETTLE: begin
                if (!pd_s) begin
                    r_d.st       = PS_PARK;
                    r_d.park_cnt = '0;
                end else if (tick_i) begin
                    if (r_q.settle_cnt == ST_W'(SETTLE_TICKS - 1)) r_d.st = PS_RUN;
                    else r_d.settle_cnt = r_q.settle_cnt + ST_W'(1);
                end
            end
            default: r_d.st = PS_OFF;
        endcase
        r_d.osc_en   = (r_d.st != PS_OFF);
        r_d.synth_en = !(r_d.st inside {PS_SYNOFF, PS_OFF});
        r_d.valid    = (r_d.st == PS_RUN);
    end

    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) r_q <= SEQ_RST;
        else        r_q <= r_d;
    end

    for (genvar g = 0; g < NGRP; g++) begin : g_want
        if (STOP_MASK[g]) begin : g_stoppable
            assign want[g] = (r_q.st == PS_RUN) && r_q.stop;
        end else begin : g_fixed
            assign want[g] = (r_q.st == PS_RUN);
        end
    end

    clkpwr_gate #(.NGRP(NGRP)) u_gate (
        .clk    (ref_clk),
        .rst_n  (rst_n),
        .want_i (want),
        .on_o   (gate_on),
        .gclk_o (gclk_o)
    );

    assign osc_en_o    = r_q.osc_en;
    assign synth_en_o  = r_q.synth_en;
    assign sel_o       = r_q.sel;
    assign clk_valid_o = r_q.valid;

    // Outputs are parked before the synthesizer loses its enable.
    assert_synth_after_park_R2: assert property (@(posedge ref_clk) disable iff (!rst_n)
        $fell(r_q.synth_en) |-> (gate_on == '0));

    // The oscillator is disabled only once the synthesizer already is.
    assert_osc_after_synth_R2: assert property (@(posedge ref_clk) disable iff (!rst_n)
        $fell(r_q.osc_en) |-> !r_q.synth_en);

    // Valid is raised only when settling ends on a sampled tick.
    assert_valid_from_settle_R4: assert property (@(posedge ref_clk) disable iff (!rst_n)
        $rose(r_q.valid) |-> ($past(r_q.st) == PS_SETTLE && $past(tick_i)));

    // Select capture is frozen outside the running state.
    assert_sel_hold_R6: assert property (@(posedge ref_clk) disable iff (!rst_n)
        ($past(r_q.st) != PS_RUN) |-> $stable(r_q.sel));

    // Stop sampling is frozen outside the running state.
    assert_stop_hold_R6: assert property (@(posedge ref_clk) disable iff (!rst_n)
        ($past(r_q.st) != PS_RUN) |-> $stable(r_q.stop));
endmodule

// File: tb/clkpwr_seq_tb.sv
module clkpwr_seq_tb;
    localparam int              NGRP         = 2;
    localparam int              SEL_W        = 3;
    localparam logic [NGRP-1:0] STOP_MASK    = 2'b01;
    localparam int              PARK_CYC     = 2;
    localparam int              SETTLE_TICKS = 25;
    localparam logic [NGRP-1:0] ALL          = '1;

    logic             ref_clk = 1'b0;
    logic             rst_n;
    logic             pd_req_n;
    logic             stop_n;
    logic [SEL_W-1:0] sel_i;
    logic             tick_i = 1'b0;
    logic             osc_en_o, synth_en_o, clk_valid_o;
    logic [NGRP-1:0]  gclk_o;
    logic [SEL_W-1:0] sel_o;

    int checks = 0;
    int fails  = 0;
    bit tick_run = 1'b1;

    always #10 ref_clk = ~ref_clk;

    clkpwr_seq #(
        .NGRP(NGRP), .SEL_W(SEL_W), .STOP_MASK(STOP_MASK),
        .PARK_CYC(PARK_CYC), .SETTLE_TICKS(SETTLE_TICKS)
    ) u_dut (
        .ref_clk(ref_clk), .rst_n(rst_n), .pd_req_n(pd_req_n), .stop_n(stop_n),
        .sel_i(sel_i), .tick_i(tick_i), .osc_en_o(osc_en_o), .synth_en_o(synth_en_o),
        .gclk_o(gclk_o), .sel_o(sel_o), .clk_valid_o(clk_valid_o)
    );

    // Randomly spaced settling ticks, changed on the falling edge.
    always @(negedge ref_clk) tick_i <= tick_run && (($urandom % 3) == 0);

    function automatic logic [NGRP-1:0] run_pattern(input bit stopped);
        return stopped ? (ALL & ~STOP_MASK) : ALL;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic smp;
        @(posedge ref_clk);
        #5;
    endtask

    task automatic drv_edge;
        @(negedge ref_clk);
    endtask

    task automatic wait_settle(input string req);
        int cnt = 0;
        bit early = 1'b0;
        for (int i = 0; i < 5000; i++) begin
            smp;
            if (tick_i) cnt++;
            if (cnt == SETTLE_TICKS) break;
            if (clk_valid_o) early = 1'b1;
        end
        chk(!early, {req, " valid low while settling"}, 32'(early), 0);
        chk(clk_valid_o == 1'b1, {req, " valid on last tick"}, 32'(clk_valid_o), 1);
        smp;
        chk(gclk_o == ALL, {req, " outputs resume"}, 32'(gclk_o), 32'(ALL));
    endtask

    task automatic pd_entry(input logic [NGRP-1:0] exp_run, input string req);
        drv_edge;
        pd_req_n = 1'b0;
        smp;
        smp;
        smp;
        chk(gclk_o == exp_run, {req, " outputs at a+2"}, 32'(gclk_o), 32'(exp_run));
        smp;
        chk(gclk_o == '0, {req, " outputs parked a+3"}, 32'(gclk_o), 0);
        chk(osc_en_o && synth_en_o, {req, " enables held while parking"},
            32'({osc_en_o, synth_en_o}), 3);
        chk(clk_valid_o == 1'b0, {req, " valid low"}, 32'(clk_valid_o), 0);
        for (int k = 4; k <= PARK_CYC + 1; k++) smp;
        smp;
        chk(!synth_en_o && osc_en_o, {req, " synth off first"},
            32'({osc_en_o, synth_en_o}), 2);
        smp;
        chk(!synth_en_o && !osc_en_o, {req, " osc off after synth"},
            32'({osc_en_o, synth_en_o}), 0);
    endtask

    task automatic wake(input string req);
        drv_edge;
        pd_req_n = 1'b1;
        smp;
        smp;
        chk(osc_en_o == 1'b0, {req, " osc still off b+1"}, 32'(osc_en_o), 0);
        smp;
        chk(osc_en_o && synth_en_o, {req, " enables on b+2"}, 32'({osc_en_o, synth_en_o}), 3);
        chk(gclk_o == '0 && !clk_valid_o, {req, " outputs held during settle"},
            32'({clk_valid_o, gclk_o}), 0);
    endtask

    initial begin
        repeat (100000) @(posedge ref_clk);
        fails++;
        $display("FAIL watchdog all-R actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [SEL_W-1:0] v;
        logic [SEL_W-1:0] held;
        void'($urandom(32'd20240611));
        rst_n = 1'b0; pd_req_n = 1'b1; stop_n = 1'b1; sel_i = '0;
        repeat (3) @(negedge ref_clk);
        #1;
        chk(gclk_o == '0 && osc_en_o && synth_en_o && !clk_valid_o && sel_o == '0,
            "R1 in reset", 32'({gclk_o, osc_en_o, synth_en_o, clk_valid_o, sel_o}), 32'h30);
        drv_edge;
        rst_n = 1'b1;
        smp;
        chk(gclk_o == '0 && osc_en_o && synth_en_o && !clk_valid_o,
            "R1 after reset", 32'({gclk_o, osc_en_o, synth_en_o, clk_valid_o}), 32'h6);
        // Cold start: the first sample already counted one edge.
        begin
            int cnt = tick_i ? 1 : 0;
            bit early = 1'b0;
            while (cnt < SETTLE_TICKS) begin
                if (clk_valid_o) early = 1'b1;
                smp;
                if (tick_i) cnt++;
            end
            chk(!early && clk_valid_o, "R8 cold start settle", 32'({early, clk_valid_o}), 1);
            smp;
            chk(gclk_o == ALL, "R8 outputs after cold start", 32'(gclk_o), 32'(ALL));
        end

        // R7: single value per high phase, zero in low phase.
        for (int i = 0; i < 12; i++) begin
            logic [NGRP-1:0] a, b, c;
            @(posedge ref_clk); #1; a = gclk_o; #8; b = gclk_o; #6; c = gclk_o;
            chk(a == b && a == ALL && c == '0, "R7 full pulse",
                32'({a, b, c}), 32'({ALL, ALL, 2'b00}));
        end

        // R6: select capture while running.
        for (int i = 0; i < 8; i++) begin
            drv_edge;
            v = SEL_W'($urandom);
            sel_i = v;
            smp;
            chk(sel_o == v, "R6 select capture", 32'(sel_o), 32'(v));
        end

        // R5: stop and restart latency with random hold times.
        for (int i = 0; i < 6; i++) begin
            int hold = $urandom % 4;
            drv_edge; stop_n = 1'b0;
            smp;
            chk(gclk_o == run_pattern(0), "R5 stop not yet at e", 32'(gclk_o), 32'(run_pattern(0)));
            smp;
            chk(gclk_o == run_pattern(1), "R5 stopped at e+1", 32'(gclk_o), 32'(run_pattern(1)));
            for (int k = 0; k < hold; k++) begin
                smp;
                chk(gclk_o == run_pattern(1), "R5 stays stopped", 32'(gclk_o), 32'(run_pattern(1)));
            end
            drv_edge; stop_n = 1'b1;
            smp;
            chk(gclk_o == run_pattern(1), "R5 start not yet at e", 32'(gclk_o), 32'(run_pattern(1)));
            smp;
            chk(gclk_o == run_pattern(0), "R5 started at e+1", 32'(gclk_o), 32'(run_pattern(0)));
        end

        // R2 entry from running, then R6 inputs ignored while off.
        held = sel_o;
        pd_entry(ALL, "R2");
        for (int i = 0; i < 6; i++) begin
            drv_edge;
            sel_i  = SEL_W'($urandom);
            stop_n = 1'($urandom);
            smp;
            chk(sel_o == held && gclk_o == '0, "R6 ignored in power down",
                32'({gclk_o, sel_o}), 32'(held));
        end
        drv_edge; stop_n = 1'b1;

        // R3 wake, R9 power down again mid-settle, then R4 full settle.
        wake("R3");
        repeat (3) smp;
        pd_entry('0, "R9");
        chk(clk_valid_o == 1'b0, "R9 valid never rose", 32'(clk_valid_o), 0);
        wake("R3 second");
        wait_settle("R4");

        // Random power cycles.
        for (int r = 0; r < 4; r++) begin
            repeat ($urandom % 6 + 1) smp;
            pd_entry(ALL, "R2 random");
            repeat ($urandom % 8) smp;
            wake("R3 random");
            wait_settle("R4 random");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule